// File: doc/BRIEF.md
# Snapshot Probe Register Bank

This block holds a wide bank of probe bits behind a narrow memory-mapped word bus. Software drives the probe outputs and a matching set of per-bit direction flags by writing 32-bit words, and it reads the probe inputs back through the same words. The probe is wider than the bus, so without help a read of every input would take several transfers, each seeing the pins at a different moment.

To get one coherent picture, a control word carries a sample bit. Setting it loads every probe input into the output data register in one clock edge. That register is otherwise idle for bits that are used as inputs. The sample bit then clears itself. A second control bit picks the source for reads of the data words: either the live pins or the registered value. With the registered value selected, software reads the frozen snapshot one word at a time. The direction flags are only stored and presented at an output. Pad logic and the bus fabric are not part of this block.

Top module: `probe_bank`

## Requirements
- R1: On synchronous reset `probe_out`, `probe_dir`, the read-source select and `bus_rvalid` are all 0, so after reset reads of the data words return the live `probe_in` word.
- R2: A write accepted at word address k, for k from 0 to 3, updates `probe_out[32k+31:32k]`, one byte for each set bit of `bus_wstrb` (bit j covers data bits 8j+7:8j). Bytes whose strobe is clear keep their value.
- R3: A write to word address 4+k, for k from 0 to 3, updates `probe_dir[32k+31:32k]` under the same byte strobes. Reads of these addresses return the stored flags.
- R4: Word address 8 is the control word. Writing it with strobe bit 0 set and data bit 0 set makes the data register load all 128 bits of `probe_in` together. The load happens on the clock edge that follows the edge accepting the write, and it takes the pin values present at that later edge.
- R5: The sample bit clears itself and reads back as 0. Writing it in back-to-back cycles gives one capture only. A later write made after the bit has cleared gives a new capture.
- R6: Control bit 1 is the read-source select. When it is 1, reads of word addresses 0 to 3 return the data register. When it is 0, they return the live `probe_in` word.
- R7: A read of the control word returns the read-source select in bit 1 and 0 in every other bit. Control bit 1 is written only when strobe bit 0 is set.
- R8: When a capture and a data-word write fall on the same clock edge, the captured pin values win for all bits.
- R9: Each read accepted while `bus_valid` and `bus_ready` are high raises `bus_rvalid` for exactly one cycle, one clock after acceptance, with `bus_rdata` valid in that cycle. Writes never raise `bus_rvalid`.
- R10: Word addresses 9 to 15 read as 0, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_valid | input | 1 | Access request |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_wstrb | input | 4 | Byte write strobes |
| bus_ready | output | 1 | Block can accept an access (low during reset) |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read is accepted |
| bus_rdata | output | 32 | Read data |
| probe_in | input | 128 | Live probe input pins |
| probe_out | output | 128 | Data register, drives the probe outputs |
| probe_dir | output | 128 | Stored per-bit direction flags |

## Verification
The hardest situation to reach is a sample bit that is written in two consecutive cycles while the pins change in between. Only then does a design that captures on a level, rather than on an edge, load a second and wrong snapshot. The bench holds the control write for two cycles and changes `probe_in` right after the first capture edge. It then checks that the first pin value remains, and that a separate later write captures the new one. A second awkward case is a data write that lands on the same edge as a capture. The bench reaches it by issuing the data write directly after the sample write, so that it is accepted on the capture edge.

// File: rtl/probe_pkg.sv
package probe_pkg;

  typedef enum logic [1:0] {
    RGN_DATA,
    RGN_DIR,
    RGN_CTRL,
    RGN_NONE
  } region_e;

  localparam int unsigned CTRL_SAMPLE_BIT = 0;
  localparam int unsigned CTRL_RSEL_BIT   = 1;

  // Map a word address onto the register region it belongs to.
  function automatic region_e region_of(input int unsigned addr, input int unsigned nwords);
    if (addr < nwords)          return RGN_DATA;
    else if (addr < 2 * nwords) return RGN_DIR;
    else if (addr == 2 * nwords) return RGN_CTRL;
    return RGN_NONE;
  endfunction

  // Control word readback: sample reads as 0, select shown in its own bit.
  function automatic logic [1:0] ctrl_bits(input logic rsel);
    return {rsel, 1'b0};
  endfunction

endpackage

// File: rtl/probe_edge_det.sv
module probe_edge_det (
  input  logic clk,
  input  logic rst,
  input  logic sample_set,
  output logic sample_q,
  output logic cap_pulse
);
  logic sample_d;

  // The sample bit holds only while it is being rewritten, so it clears itself.
  always_ff @(posedge clk) begin
    if (rst) begin
      sample_q <= 1'b0;
      sample_d <= 1'b0;
    end else begin
      sample_q <= sample_set;
      sample_d <= sample_q;
    end
  end

  assign cap_pulse = sample_q & ~sample_d;
endmodule

// File: rtl/probe_word_reg.sv
module probe_word_reg #(
  parameter int unsigned WIDTH  = 128,
  parameter int unsigned BUS_W  = 32,
  localparam int unsigned NWORDS = WIDTH / BUS_W,
  localparam int unsigned NBYTES = BUS_W / 8,
  localparam int unsigned IDX_W  = (NWORDS > 1) ? $clog2(NWORDS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [BUS_W-1:0]  wdata,
  input  logic [NBYTES-1:0] wstrb,
  input  logic              cap_en,
  input  logic [WIDTH-1:0]  cap_data,
  output logic [WIDTH-1:0]  q
);
  for (genvar w = 0; w < NWORDS; w++) begin : g_word
    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
      localparam int unsigned LO = w * BUS_W + b * 8;
      logic byte_we;
      assign byte_we = wr_en && (wr_idx == IDX_W'(w)) && wstrb[b];

      // A capture takes the whole bank and overrides any bus write.
      always_ff @(posedge clk) begin
        if (rst)          q[LO +: 8] <= '0;
        else if (cap_en)  q[LO +: 8] <= cap_data[LO +: 8];
        else if (byte_we) q[LO +: 8] <= wdata[b*8 +: 8];
      end
    end
  end
endmodule

// File: rtl/probe_bus_ctl.sv
module probe_bus_ctl
  import probe_pkg::*;
#(
  parameter int unsigned WIDTH  = 128,
  parameter int unsigned BUS_W  = 32,
  parameter int unsigned ADDR_W = 4,
  localparam int unsigned NWORDS = WIDTH / BUS_W,
  localparam int unsigned IDX_W  = (NWORDS > 1) ? $clog2(NWORDS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              valid,
  input  logic              ready,
  input  logic              write,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        ctrl_wdata,
  input  logic              ctrl_strb,
  input  logic [WIDTH-1:0]  data_q,
  input  logic [WIDTH-1:0]  dir_q,
  input  logic [WIDTH-1:0]  pins,
  output logic              data_we,
  output logic              dir_we,
  output logic [IDX_W-1:0]  word_idx,
  output logic              sample_set,
  output logic              rsel,
  output logic              rvalid,
  output logic [BUS_W-1:0]  rdata
);
  region_e          rgn;
  logic             wr_acc, rd_acc, ctrl_we;
  logic [WIDTH-1:0] rd_src;
  logic [BUS_W-1:0] rd_next;

  assign rgn      = region_of(int'(addr), NWORDS);
  assign wr_acc   = valid & ready & write;
  assign rd_acc   = valid & ready & ~write;
  assign word_idx = addr[IDX_W-1:0];
  assign data_we  = wr_acc && (rgn == RGN_DATA);
  assign dir_we   = wr_acc && (rgn == RGN_DIR);
  assign ctrl_we  = wr_acc && (rgn == RGN_CTRL) && ctrl_strb;
  assign sample_set = ctrl_we && ctrl_wdata[CTRL_SAMPLE_BIT];

  always_ff @(posedge clk) begin
    if (rst)          rsel <= 1'b0;
    else if (ctrl_we) rsel <= ctrl_wdata[CTRL_RSEL_BIT];
  end

  assign rd_src = rsel ? data_q : pins;

  always_comb begin
    case (rgn)
      RGN_DATA: rd_next = rd_src[word_idx * BUS_W +: BUS_W];
      RGN_DIR:  rd_next = dir_q[word_idx * BUS_W +: BUS_W];
      RGN_CTRL: rd_next = BUS_W'(ctrl_bits(rsel));
      default:  rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rvalid <= 1'b0;
      rdata  <= '0;
    end else begin
      rvalid <= rd_acc;
      if (rd_acc) rdata <= rd_next;
    end
  end
endmodule

// File: rtl/probe_bank.sv
module probe_bank #(
  parameter int unsigned PROBE_W = 128,
  parameter int unsigned BUS_W   = 32,
  parameter int unsigned ADDR_W  = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bus_valid,
  input  logic                 bus_write,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [BUS_W-1:0]     bus_wdata,
  input  logic [BUS_W/8-1:0]   bus_wstrb,
  output logic                 bus_ready,
  output logic                 bus_rvalid,
  output logic [BUS_W-1:0]     bus_rdata,
  input  logic [PROBE_W-1:0]   probe_in,
  output logic [PROBE_W-1:0]   probe_out,
  output logic [PROBE_W-1:0]   probe_dir
);
  localparam int unsigned NWORDS = PROBE_W / BUS_W;
  localparam int unsigned IDX_W  = (NWORDS > 1) ? $clog2(NWORDS) : 1;

  logic             data_we, dir_we, sample_set, sample_q, cap_pulse, rsel;
  logic [IDX_W-1:0] word_idx;

  assign bus_ready = ~rst;

  probe_bus_ctl #(.WIDTH(PROBE_W), .BUS_W(BUS_W), .ADDR_W(ADDR_W)) u_ctl (
    .clk(clk), .rst(rst), .valid(bus_valid), .ready(bus_ready), .write(bus_write),
    .addr(bus_addr), .ctrl_wdata(bus_wdata[1:0]), .ctrl_strb(bus_wstrb[0]),
    .data_q(probe_out), .dir_q(probe_dir), .pins(probe_in),
    .data_we(data_we), .dir_we(dir_we), .word_idx(word_idx),
    .sample_set(sample_set), .rsel(rsel), .rvalid(bus_rvalid), .rdata(bus_rdata)
  );

  probe_edge_det u_edge (
    .clk(clk), .rst(rst), .sample_set(sample_set),
    .sample_q(sample_q), .cap_pulse(cap_pulse)
  );

  probe_word_reg #(.WIDTH(PROBE_W), .BUS_W(BUS_W)) u_data (
    .clk(clk), .rst(rst), .wr_en(data_we), .wr_idx(word_idx),
    .wdata(bus_wdata), .wstrb(bus_wstrb),
    .cap_en(cap_pulse), .cap_data(probe_in), .q(probe_out)
  );

  probe_word_reg #(.WIDTH(PROBE_W), .BUS_W(BUS_W)) u_dir (
    .clk(clk), .rst(rst), .wr_en(dir_we), .wr_idx(word_idx),
    .wdata(bus_wdata), .wstrb(bus_wstrb),
    .cap_en(1'b0), .cap_data({PROBE_W{1'b0}}), .q(probe_dir)
  );
endmodule

// File: rtl/probe_bank_chk.sv
module probe_bank_chk #(
  parameter int unsigned PROBE_W = 128,
  parameter int unsigned ADDR_W  = 4,
  parameter int unsigned NWORDS  = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               bus_valid,
  input logic               bus_ready,
  input logic               bus_write,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic               bus_rvalid,
  input logic [PROBE_W-1:0] probe_in,
  input logic [PROBE_W-1:0] probe_out,
  input logic [PROBE_W-1:0] probe_dir,
  input logic               cap_pulse
);
  logic rd_acc, wr_unmapped;
  assign rd_acc      = bus_valid && bus_ready && !bus_write;
  assign wr_unmapped = bus_valid && bus_ready && bus_write && (int'(bus_addr) > 2 * NWORDS);

  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (probe_out == '0 && probe_dir == '0 && !bus_rvalid));

  assert_read_latency_R9: assert property (@(posedge clk) disable iff (rst)
    rd_acc |=> bus_rvalid);

  assert_no_stray_rvalid_R9: assert property (@(posedge clk) disable iff (rst)
    !rd_acc |=> !bus_rvalid);

  assert_capture_all_bits_R4: assert property (@(posedge clk) disable iff (rst)
    cap_pulse |=> (probe_out == $past(probe_in)));

  assert_single_capture_R5: assert property (@(posedge clk) disable iff (rst)
    cap_pulse |=> !cap_pulse);

  assert_unmapped_ignored_R10: assert property (@(posedge clk) disable iff (rst)
    (wr_unmapped && !cap_pulse) |=> ($stable(probe_out) && $stable(probe_dir)));
endmodule

bind probe_bank probe_bank_chk #(.PROBE_W(PROBE_W), .ADDR_W(ADDR_W), .NWORDS(NWORDS)) u_chk (.*);

// File: tb/sim_probe_bank.sv
module sim_probe_bank;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         bus_valid = 1'b0, bus_write = 1'b0;
  logic [3:0]   bus_addr = '0;
  logic [31:0]  bus_wdata = '0;
  logic [3:0]   bus_wstrb = '0;
  logic         bus_ready, bus_rvalid;
  logic [31:0]  bus_rdata;
  logic [127:0] probe_in = '0;
  logic [127:0] probe_out, probe_dir;

  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;

  probe_bank u0 (.*);

  // {is_write, addr, data, strobes, expected read data}
  localparam int NV = 21;
  localparam logic [72:0] VEC [NV] = '{
    {1'b1, 4'd0,  32'hA5A5_0001, 4'hF, 32'h0},
    {1'b1, 4'd1,  32'h1234_5678, 4'hF, 32'h0},
    {1'b1, 4'd2,  32'hFFFF_FFFF, 4'h3, 32'h0},
    {1'b1, 4'd3,  32'hAB00_CDEF, 4'h8, 32'h0},
    {1'b1, 4'd4,  32'h0F0F_0F0F, 4'hF, 32'h0},
    {1'b1, 4'd7,  32'hF000_0000, 4'hF, 32'h0},
    {1'b0, 4'd8,  32'h0,         4'h0, 32'h0},
    {1'b1, 4'd8,  32'h0000_0002, 4'h1, 32'h0},
    {1'b0, 4'd0,  32'h0,         4'h0, 32'hA5A5_0001},
    {1'b0, 4'd1,  32'h0,         4'h0, 32'h1234_5678},
    {1'b0, 4'd2,  32'h0,         4'h0, 32'h0000_FFFF},
    {1'b0, 4'd3,  32'h0,         4'h0, 32'hAB00_0000},
    {1'b0, 4'd4,  32'h0,         4'h0, 32'h0F0F_0F0F},
    {1'b0, 4'd7,  32'h0,         4'h0, 32'hF000_0000},
    {1'b0, 4'd8,  32'h0,         4'h0, 32'h0000_0002},
    {1'b1, 4'd12, 32'hFFFF_FFFF, 4'hF, 32'h0},
    {1'b0, 4'd12, 32'h0,         4'h0, 32'h0},
    {1'b0, 4'd5,  32'h0,         4'h0, 32'h0},
    {1'b1, 4'd8,  32'h0000_0000, 4'h1, 32'h0},
    {1'b0, 4'd0,  32'h0,         4'h0, 32'h1111_0001},
    {1'b0, 4'd3,  32'h0,         4'h0, 32'h4444_0004}
  };

  localparam logic [127:0] PINS0 = {32'h4444_0004, 32'h3333_0003, 32'h2222_0002, 32'h1111_0001};
  localparam logic [127:0] Q1    = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210;
  localparam logic [127:0] Q2    = 128'hDEAD_0000_BEEF_1111_CAFE_2222_F00D_3333;
  localparam logic [127:0] Q3    = 128'h5555_AAAA_5555_AAAA_5555_AAAA_5555_AAAA;

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Called at a negedge; returns at the negedge after the accepting edge.
  task automatic do_write(input logic [3:0] a, input logic [31:0] d, input logic [3:0] s);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d; bus_wstrb = s;
    @(posedge clk); @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0; bus_wstrb = '0;
  endtask

  task automatic do_read(input logic [3:0] a, output logic [31:0] d, output logic rv);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(posedge clk); @(negedge clk);
    rv = bus_rvalid; d = bus_rdata;
    bus_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    tests++; fails++;
    $display("FAIL R9 watchdog actual=hung expected=finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    logic        rv;
    string       tag;

    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 probe_out after reset", probe_out, '0);
    check("R1 probe_dir after reset", probe_dir, '0);
    check("R1 rvalid after reset", 128'(bus_rvalid), 128'd0);
    rst = 1'b0;
    probe_in = PINS0;

    // Vector walk: byte-strobed writes, readback through both sources, unmapped space.
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][72]) begin
        do_write(VEC[i][71:68], VEC[i][67:36], VEC[i][35:32]);
        check("R9 no rvalid after write", 128'(bus_rvalid), 128'd0);
      end else begin
        do_read(VEC[i][71:68], rd, rv);
        check("R9 rvalid on read", 128'(rv), 128'd1);
        if (VEC[i][71:68] < 4'd4)       tag = "R6 data word read";
        else if (VEC[i][71:68] < 4'd8)  tag = "R3 dir word read";
        else if (VEC[i][71:68] == 4'd8) tag = "R7 ctrl read";
        else                            tag = "R10 unmapped read";
        check(tag, 128'(rd), 128'(VEC[i][31:0]));
      end
    end
    @(negedge clk);
    check("R9 rvalid single cycle", 128'(bus_rvalid), 128'd0);
    check("R2 probe_out after strobed writes", probe_out,
          {32'hAB00_0000, 32'h0000_FFFF, 32'h1234_5678, 32'hA5A5_0001});
    check("R3 probe_dir after writes", probe_dir,
          {32'hF000_0000, 64'h0, 32'h0F0F_0F0F});

    // R10: unmapped write leaves all state alone.
    do_write(4'd9, 32'hFFFF_FFFF, 4'hF);
    @(negedge clk);
    check("R10 probe_out after unmapped write", probe_out,
          {32'hAB00_0000, 32'h0000_FFFF, 32'h1234_5678, 32'hA5A5_0001});
    check("R10 probe_dir after unmapped write", probe_dir, {32'hF000_0000, 64'h0, 32'h0F0F_0F0F});

    // R5: sample written on two back-to-back cycles, pins changed after the first capture.
    probe_in = Q1;
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 4'd8; bus_wdata = 32'h3; bus_wstrb = 4'h1;
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0; bus_wstrb = '0;
    probe_in = Q2;
    repeat (3) @(negedge clk);
    check("R5 held sample captures once", probe_out, Q1);
    do_read(4'd8, rd, rv);
    check("R5 sample bit reads 0", 128'(rd), 128'h2);

    // R4: a fresh write captures at the following edge, all words at once.
    do_write(4'd8, 32'h3, 4'h1);
    check("R4 no capture on accepting edge", probe_out, Q1);
    probe_in = Q3;
    @(negedge clk);
    check("R4 capture takes pins at next edge", probe_out, Q3);
    probe_in = Q2;
    for (int w = 0; w < 4; w++) begin
      do_read(4'(w), rd, rv);
      check("R4 snapshot word readback", 128'(rd), 128'(Q3[w*32 +: 32]));
    end

    // R8: data write accepted on the capture edge loses to the capture.
    probe_in = Q1;
    do_write(4'd8, 32'h3, 4'h1);
    do_write(4'd0, 32'hDEAD_BEEF, 4'hF);
    check("R8 capture beats same-edge write", probe_out, Q1);
    do_write(4'd0, 32'hDEAD_BEEF, 4'hF);
    check("R2 plain write after capture", 128'(probe_out[31:0]), 128'h0000_0000_DEAD_BEEF);

    // R7: control bit 1 ignored without strobe bit 0.
    do_write(4'd8, 32'h0, 4'hE);
    do_read(4'd8, rd, rv);
    check("R7 ctrl needs strobe 0", 128'(rd), 128'h2);

    // R1: reset in mid-run clears everything and returns reads to live pins.
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R1 probe_out after mid reset", probe_out, '0);
    check("R1 probe_dir after mid reset", probe_dir, '0);
    rst = 1'b0;
    do_read(4'd8, rd, rv);
    check("R1 select cleared", 128'(rd), 128'h0);
    do_read(4'd2, rd, rv);
    check("R1 live pins after reset", 128'(rd), 128'(Q1[95:64]));

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule